// File: doc/BRIEF.md
# Tagged Status Snapshot Register

This block gives software a status word it can trust. The live status bits come in as plain inputs and change at any time. Software does not read them directly. It writes an 8-bit control word that asks for a snapshot and carries a 6-bit tag. The block then captures the live bits and the tag into one 32-bit word, all on the same clock edge. Software polls that word until the tag it chose appears, so it knows the rest of the word is fresh and not left over from an earlier request. The usual next tag is the current tag plus one, modulo 64.

Four update modes are selected by the control word:
- Hold stops all updates and keeps the last snapshot.
- Single takes one snapshot with the written tag.
- Single-keep takes one snapshot and keeps the tag already shown.
- Auto takes snapshots repeatedly at a fixed parameterised interval and increments the tag on each one.

A one-cycle strobe marks every new snapshot, so a downstream transport can forward it. That transport is not part of this block. The block has no streaming data path: every pin is plain control or status, with no valid/ready handshake and no back-pressure.

Top module: `stag_status_snap`

## Requirements
- R1: After reset the status word is all zeros and the snapshot strobe is low.
- R2: Control word fields: bits [7:6] hold the mode (0 hold, 1 single, 2 single-keep, 3 auto) and bits [5:0] hold the tag. In the status word, bits [31:26] hold the tag and bits [25:0] are the live bits as captured.
- R3: A single-mode write sampled on clock edge E updates the status word on edge E+1 with the written tag and the live bits present at E+1. The strobe is high for exactly the cycle after E+1, and no further update follows.
- R4: A single-keep write also updates on edge E+1 with fresh live bits, but the tag stays at the value the status word already shows.
- R5: A hold write stops all later updates, including an auto sequence that is running. The status word then stays constant however the live bits change.
- R6: An auto write sampled on edge E updates on E+1 with the written tag. It then updates every PERIOD cycles (E+1+k*PERIOD) with the tag incremented by one each time and fresh live bits.
- R7: In auto mode the tag wraps from 63 to 0.
- R8: The status word changes only on an edge that raises the strobe, and the tag and live bits change together.
- R9: When the control write enable is low, the control word has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control write enable, one cycle per write |
| ctl_word | input | 8 | Control word: mode [7:6], tag [5:0] |
| live_bits | input | 26 | Live status bits to be captured |
| status_word | output | 32 | Snapshot: tag [31:26], captured bits [25:0] |
| snap_stb | output | 1 | High for one cycle when a new snapshot is visible |

## Verification
A write sampled on edge E produces its snapshot on edge E+1. The bench drives inputs on falling edges, so it checks the word and the strobe on the falling edge after E+1, which is the first falling edge after the write task returns. In auto mode, later snapshots fall due PERIOD falling edges apart. The bench steps exactly that many falling edges, checks that the strobe stays low in between, and checks the tag and captured bits on the due edge. After hold and disabled writes, the bench watches the word for several PERIOD spans to show it does not change. A falling-edge monitor flags any change of the word that is not accompanied by the strobe.

// File: rtl/stag_pkg.sv
package stag_pkg;
  localparam int CTL_W  = 8;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MD_HOLD = 2'd0,
    MD_ONCE = 2'd1,
    MD_KEEP = 2'd2,
    MD_AUTO = 2'd3
  } snap_mode_e;
endpackage

// File: rtl/stag_ctl_dec.sv
module stag_ctl_dec
  import stag_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic                 wr,
  input  logic [CTL_W-1:0]     word,
  input  logic                 fire,
  input  logic [TAG_W-1:0]     tag_q,
  input  logic [TAG_W-1:0]     shown_tag,
  output logic                 stop,
  output logic                 arm_once,
  output logic                 arm_auto,
  output logic                 load_tag,
  output logic [TAG_W-1:0]     new_tag
);
  snap_mode_e mode;
  assign mode = snap_mode_e'(word[CTL_W-1 -: MODE_W]);

  always_comb begin
    stop     = 1'b0;
    arm_once = 1'b0;
    arm_auto = 1'b0;
    load_tag = 1'b0;
    new_tag  = word[TAG_W-1:0];
    if (wr) begin
      unique case (mode)
        MD_HOLD: stop = 1'b1;
        MD_ONCE: begin arm_once = 1'b1; load_tag = 1'b1; end
        MD_KEEP: begin
          arm_once = 1'b1;
          load_tag = 1'b1;
          // if a snapshot lands this edge, the tag it shows is tag_q
          new_tag  = fire ? tag_q : shown_tag;
        end
        MD_AUTO: begin arm_auto = 1'b1; load_tag = 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/stag_seq.sv
module stag_seq #(
  parameter int TAG_W  = 6,
  parameter int PERIOD = 16,
  localparam int CNT_W = $clog2(PERIOD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop,
  input  logic             arm_once,
  input  logic             arm_auto,
  input  logic             load_tag,
  input  logic [TAG_W-1:0] new_tag,
  output logic             fire,
  output logic [TAG_W-1:0] tag_q
);
  logic             pend_q;
  logic             auto_q;
  logic [CNT_W-1:0] cnt_q;

  assign fire = pend_q | (auto_q & (cnt_q == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      auto_q <= 1'b0;
      cnt_q  <= '0;
    end else if (stop) begin
      pend_q <= 1'b0;
      auto_q <= 1'b0;
    end else if (arm_auto) begin
      pend_q <= 1'b0;
      auto_q <= 1'b1;
      cnt_q  <= '0;
    end else if (arm_once) begin
      pend_q <= 1'b1;
      auto_q <= 1'b0;
    end else if (fire) begin
      pend_q <= 1'b0;
      if (auto_q) cnt_q <= CNT_W'(PERIOD - 1);
    end else if (auto_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                tag_q <= '0;
    else if (load_tag)         tag_q <= new_tag;
    else if (fire && auto_q)   tag_q <= tag_q + 1'b1;
  end

  assert_tag_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && auto_q && !load_tag && tag_q == '1) |=> (tag_q == '0));

  assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !fire);
endmodule

// File: rtl/stag_snap_reg.sv
module stag_snap_reg #(
  parameter int TAG_W  = 6,
  parameter int LIVE_W = 26
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fire,
  input  logic [TAG_W-1:0]        tag,
  input  logic [LIVE_W-1:0]       live,
  output logic [TAG_W+LIVE_W-1:0] word_q,
  output logic                    stb_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= fire;
      if (fire) word_q <= {tag, live};
    end
  end

  assert_change_with_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_q) |-> stb_q);
endmodule

// File: rtl/stag_status_snap.sv
module stag_status_snap
  import stag_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int WORD_W = 32,
  parameter int PERIOD = 16,
  localparam int LIVE_W = WORD_W - TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_word,
  input  logic [LIVE_W-1:0] live_bits,
  output logic [WORD_W-1:0] status_word,
  output logic              snap_stb
);
  logic             stop, arm_once, arm_auto, load_tag, fire;
  logic [TAG_W-1:0] new_tag, tag_q;

  stag_ctl_dec #(.TAG_W(TAG_W)) u_dec (
    .wr(ctl_wr), .word(ctl_word), .fire(fire), .tag_q(tag_q),
    .shown_tag(status_word[WORD_W-1 -: TAG_W]),
    .stop(stop), .arm_once(arm_once), .arm_auto(arm_auto),
    .load_tag(load_tag), .new_tag(new_tag)
  );

  stag_seq #(.TAG_W(TAG_W), .PERIOD(PERIOD)) u_seq (
    .clk(clk), .rst_n(rst_n), .stop(stop), .arm_once(arm_once),
    .arm_auto(arm_auto), .load_tag(load_tag), .new_tag(new_tag),
    .fire(fire), .tag_q(tag_q)
  );

  stag_snap_reg #(.TAG_W(TAG_W), .LIVE_W(LIVE_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .fire(fire), .tag(tag_q), .live(live_bits),
    .word_q(status_word), .stb_q(snap_stb)
  );

  assert_once_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_word[7:6] == 2'd1) |=> ##1 snap_stb);

  assert_once_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_word[7:6] == 2'd1) |=> ##1
      (status_word[WORD_W-1 -: TAG_W] == $past(ctl_word[TAG_W-1:0], 2)));

  assert_keep_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_word[7:6] == 2'd2 && !fire) |=> ##1
      (status_word[WORD_W-1 -: TAG_W] == $past(status_word[WORD_W-1 -: TAG_W], 2)));

  assert_hold_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_word[7:6] == 2'd0) |=> ##1 !snap_stb);
endmodule

// File: tb/stag_status_snap_test.sv
module stag_status_snap_test;
  localparam int P = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_word = '0;
  logic [25:0] live_bits = '0;
  logic [31:0] status_word;
  logic        snap_stb;

  int checks = 0;
  int fails = 0;
  int r8_bad = 0;
  logic [31:0] prev_word = '0;

  always #10 clk = ~clk;

  stag_status_snap #(.PERIOD(P)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_word(ctl_word),
    .live_bits(live_bits), .status_word(status_word), .snap_stb(snap_stb)
  );

  always @(negedge clk) begin
    if (rst_n && status_word != prev_word && !snap_stb) r8_bad++;
    prev_word = status_word;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [1:0] mode, input logic [5:0] tag);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_word = {mode, tag};
    @(negedge clk);
    ctl_wr = 1'b0;
    ctl_word = 8'h00;
  endtask

  task automatic quiet_span(input string req, input int n, input logic [31:0] exp_word);
    int stbs = 0;
    for (int i = 0; i < n; i++) begin
      live_bits = live_bits + 26'h1357;
      @(negedge clk);
      if (snap_stb) stbs++;
    end
    chk({req, " no strobe"}, 32'(stbs), 32'd0);
    chk({req, " word held"}, status_word, exp_word);
  endtask

  task automatic t_reset;
    chk("R1 word", status_word, 32'h0);
    chk("R1 strobe", {31'b0, snap_stb}, 32'h0);
  endtask

  task automatic t_no_write;
    // R9: control word toggles with ctl_wr low
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      ctl_word = 8'h40 | 8'(i);
    end
    ctl_word = 8'h00;
    quiet_span("R9", 2 * P, 32'h0);
  endtask

  task automatic t_once;
    live_bits = 26'h2AB_CDEF;
    write_ctl(2'd1, 6'd37);
    @(negedge clk);
    chk("R3 strobe", {31'b0, snap_stb}, 32'h1);
    chk("R2 R3 fields", status_word, {6'd37, 26'h2AB_CDEF});
    quiet_span("R3 single only", 2 * P, {6'd37, 26'h2AB_CDEF});
  endtask

  task automatic t_keep(input logic [5:0] shown);
    live_bits = 26'h155_5555;
    write_ctl(2'd2, 6'd9);
    @(negedge clk);
    chk("R4 strobe", {31'b0, snap_stb}, 32'h1);
    chk("R4 tag kept", status_word, {shown, 26'h155_5555});
  endtask

  task automatic t_hold;
    logic [31:0] w;
    w = status_word;
    write_ctl(2'd0, 6'd12);
    quiet_span("R5 hold", 3 * P, w);
  endtask

  task automatic t_auto;
    int early;
    live_bits = 26'h000_0AAA;
    write_ctl(2'd3, 6'd62);
    @(negedge clk);
    chk("R6 first strobe", {31'b0, snap_stb}, 32'h1);
    chk("R6 first word", status_word, {6'd62, 26'h000_0AAA});
    for (int r = 1; r <= 2; r++) begin
      early = 0;
      live_bits = 26'h100_0000 + 26'(r);
      for (int k = 1; k <= P; k++) begin
        @(negedge clk);
        if (k < P && snap_stb) early++;
      end
      chk("R6 no strobe between", 32'(early), 32'd0);
      chk("R6 strobe on interval", {31'b0, snap_stb}, 32'h1);
      if (r == 1) chk("R6 tag step", status_word, {6'd63, 26'h100_0001});
      else        chk("R7 tag wrap", status_word, {6'd0, 26'h100_0002});
    end
    write_ctl(2'd0, 6'd0);
    quiet_span("R5 stops auto", 3 * P, {6'd0, 26'h100_0002});
  endtask

  task automatic t_once_edge;
    live_bits = 26'h3FF_FFFF;
    write_ctl(2'd1, 6'd63);
    @(negedge clk);
    chk("R2 R3 all ones", status_word, 32'hFFFF_FFFF);
    live_bits = 26'h0;
    write_ctl(2'd1, 6'd0);
    @(negedge clk);
    chk("R2 R3 all zeros", status_word, 32'h0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_write();
    t_once();
    t_keep(6'd37);
    t_hold();
    t_auto();
    t_keep(6'd0);
    t_once_edge();
    chk("R8 change without strobe", 32'(r8_bad), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule